// File: doc/BRIEF.md
# Store-Miss Allocation Data Cache Controller

This block is a small direct-mapped data cache front end that decides, for every store it accepts, whether the store hits, misses and pulls the line in, or misses and goes around the cache. The choice on a miss comes from one of two sources. The first is a global no-allocate bit. The second is a per-page no-allocate attribute that travels with the request. A global page-control enable decides which of the two is in force. Non-cacheable stores always go straight to memory.

The cache is split into a normal partition of 8 sets and a transient partition of 2 sets, with 16-byte lines. A per-page transient mark picks the transient partition, but only while a global transient enable is set. An allocating miss first writes back a dirty victim if there is one. It then issues a single line-read request and merges the pending store into the returned line as that line is written. Loads only look up the cache and report what they find. They never fill the cache or touch memory.

Top module: `dc_store_alloc`

## Requirements
- R1: While cfg_page_alloc_en is 0, a cacheable store miss allocates when cfg_store_noalloc is 0 and does not allocate when it is 1. Response kind codes: 0 hit, 1 allocating miss, 2 non-allocating miss or load miss, 3 non-cacheable.
- R2: While cfg_page_alloc_en is 1, a cacheable store miss allocates when req_pg_nalloc is 0 and does not when it is 1, whatever cfg_store_noalloc holds.
- R3: An allocating miss drives one fill_req_valid pulse carrying the line-aligned address. On fill_valid, the line is written with the store bytes merged over fill_data. Byte k of the 32-bit word goes to line byte 4*addr[3:2]+k. One cycle later rsp_valid carries kind 1.
- R4: An allocating miss on a write-through page writes the store to memory in the cycle the response appears. On any other page the new line is held dirty and no memory write is made.
- R5: A non-allocating store miss produces one memory write in the cycle after acceptance and no fill request, and the cache is unchanged. The write carries the line-aligned address, the word copied into all four word lanes, and mem_wr_be bit 4*addr[3:2]+k set for each req_be bit k.
- R6: While cfg_transient_en is 1 and req_pg_tmark is 1, the access uses the transient partition, indexed by line-address bit 0. In every other case it uses the normal partition, indexed by line-address bits 2:0. rsp_part reports 1 for transient.
- R7: A non-cacheable store writes only to memory and responds with kind 3. It causes no fill, and any cached copy of the line stays as it was.
- R8: A store hit updates the cached line and responds with kind 0 one cycle after acceptance. It also writes to memory only on a write-through page. Otherwise it marks the line dirty.
- R9: When an allocating miss displaces a valid dirty line, the whole victim line is written to memory with all 16 byte enables set, at the victim's address, exactly one cycle before the fill request.
- R10: req_ready stays low from the acceptance of an allocating miss until the cycle after fill_valid. Requests presented in that window are not taken.
- R11: A cacheable load returns the addressed word with rsp_hit 1 on a hit. On a miss it returns rsp_hit 0, data 0 and kind 2. A load never causes a fill or memory write.
- R12: After reset, req_ready is 1, no valid output is asserted, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 store, 0 load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store word |
| req_be | input | 4 | Store byte enables within the word |
| req_cacheable | input | 1 | Page is cacheable |
| req_wthru | input | 1 | Page is write-through |
| req_pg_tmark | input | 1 | Page requests the transient partition |
| req_pg_nalloc | input | 1 | Page requests no allocation on store miss |
| cfg_store_noalloc | input | 1 | Global no-allocate on store miss |
| cfg_page_alloc_en | input | 1 | Page attribute decides allocation instead of the global bit |
| cfg_transient_en | input | 1 | Enables the transient partition |
| rsp_valid | output | 1 | Response pulse |
| rsp_kind | output | 2 | Handling code (see R1) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_part | output | 1 | Partition used, 1 transient |
| rsp_rdata | output | 32 | Load data on hit, else 0 |
| fill_req_valid | output | 1 | Line read request pulse |
| fill_req_addr | output | 32 | Line-aligned fill address |
| fill_valid | input | 1 | Fill line present |
| fill_data | input | 128 | Fill line |
| mem_wr_valid | output | 1 | Memory write pulse |
| mem_wr_addr | output | 32 | Line-aligned write address |
| mem_wr_data | output | 128 | Write data |
| mem_wr_be | output | 16 | Byte enables over the line |

## Verification
The hardest situation to reach is an eviction that needs a write-back. A line must first be allocated on a non-write-through page so that it turns dirty. Then a second allocating store has to land on a different line address that maps to the same set, in either partition. The stimulus builds this by allocating 0x104 and then 0x18C in the normal partition. In the transient partition it allocates 0x520 and then 0x544. While each fill is held back, a stray non-cacheable store is kept on the request port to show that it is not taken. A reference model in the bench recomputes the tags, the dirty state and the merged lines, and checks every output cycle.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

  typedef enum logic [1:0] {
    K_HIT     = 2'd0,
    K_ALLOC   = 2'd1,
    K_NOALLOC = 2'd2,
    K_BYPASS  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WB   = 2'd1,
    S_WAIT = 2'd2
  } st_e;

  // partition choice: transient only when globally enabled and page marked
  function automatic logic pick_transient(logic tr_en, logic pg_tmark);
    return tr_en & pg_tmark;
  endfunction

  // allocation choice on a cacheable store miss
  function automatic logic alloc_on_miss(logic g_noalloc, logic page_ctl, logic pg_nalloc);
    return page_ctl ? ~pg_nalloc : ~g_noalloc;
  endfunction

endpackage

// File: rtl/dsa_policy.sv
module dsa_policy
  import dsa_pkg::*;
(
  input  logic  is_store,
  input  logic  cacheable,
  input  logic  hit,
  input  logic  g_noalloc,
  input  logic  page_ctl_en,
  input  logic  pg_nalloc,
  output kind_e kind
);

  logic alloc_pick;
  assign alloc_pick = alloc_on_miss(g_noalloc, page_ctl_en, pg_nalloc);

  always_comb begin
    if (!cacheable)                 kind = K_BYPASS;
    else if (hit)                   kind = K_HIT;
    else if (is_store && alloc_pick) kind = K_ALLOC;
    else                            kind = K_NOALLOC;
  end

endmodule

// File: rtl/dsa_merge.sv
module dsa_merge #(
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  localparam int WB        = WORD_W / 8,
  localparam int WORDS     = LINE_BYTES / WB,
  localparam int WSEL_W    = $clog2(WORDS),
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic [LINE_W-1:0]     base_line,
  input  logic [WSEL_W-1:0]     wsel,
  input  logic [WORD_W-1:0]     wdata,
  input  logic [WB-1:0]         be,
  output logic [LINE_W-1:0]     merged_line,
  output logic [LINE_W-1:0]     mem_data,
  output logic [LINE_BYTES-1:0] mem_be
);

  // byte lanes of the line covered by the store
  function automatic logic [LINE_BYTES-1:0] lane_mask(logic [WSEL_W-1:0] ws, logic [WB-1:0] b);
    logic [LINE_BYTES-1:0] m;
    m = '0;
    for (int k = 0; k < WB; k++) m[int'(ws) * WB + k] = b[k];
    return m;
  endfunction

  assign mem_data = {WORDS{wdata}};
  assign mem_be   = lane_mask(wsel, be);

  always_comb begin
    merged_line = base_line;
    for (int i = 0; i < LINE_BYTES; i++) begin
      if (mem_be[i]) merged_line[i*8 +: 8] = mem_data[i*8 +: 8];
    end
  end

endmodule

// File: rtl/dsa_line_store.sv
module dsa_line_store #(
  parameter int SETS    = 8,
  parameter int TAG_W   = 28,
  parameter int LINE_W  = 128,
  localparam int IDX_W  = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              wr_dirty
);

  logic [SETS-1:0]   vld_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx]   <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      line_q[wr_idx] <= wr_line;
    end
  end

  assign rd_vld   = vld_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = line_q[rd_idx];

  // R3: a written set is valid afterwards
  p_write_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)])
    else $error("written set not valid");

endmodule

// File: rtl/dc_store_alloc.sv
module dc_store_alloc
  import dsa_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NORM_SETS  = 8,
  parameter int TRAN_SETS  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  input  logic [WORD_W/8-1:0]     req_be,
  input  logic                    req_cacheable,
  input  logic                    req_wthru,
  input  logic                    req_pg_tmark,
  input  logic                    req_pg_nalloc,
  input  logic                    cfg_store_noalloc,
  input  logic                    cfg_page_alloc_en,
  input  logic                    cfg_transient_en,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_kind,
  output logic                    rsp_hit,
  output logic                    rsp_part,
  output logic [WORD_W-1:0]       rsp_rdata,
  output logic                    fill_req_valid,
  output logic [ADDR_W-1:0]       fill_req_addr,
  input  logic                    fill_valid,
  input  logic [LINE_BYTES*8-1:0] fill_data,
  output logic                    mem_wr_valid,
  output logic [ADDR_W-1:0]       mem_wr_addr,
  output logic [LINE_BYTES*8-1:0] mem_wr_data,
  output logic [LINE_BYTES-1:0]   mem_wr_be
);

  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WB     = WORD_W / 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WSEL_W = $clog2(LINE_BYTES / WB);
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int NPART  = 2;

  st_e   state_q;
  kind_e kind;

  logic              acc, req_tr, hit;
  logic              sel_vld, sel_dirty;
  logic [LA_W-1:0]   req_la, sel_tag;
  logic [LINE_W-1:0] sel_line;
  logic [WSEL_W-1:0] req_wsel;

  logic [NPART-1:0]  pv, pd;
  logic [LA_W-1:0]   ptag  [NPART];
  logic [LINE_W-1:0] pline [NPART];

  // request held across a fill
  logic [LA_W-1:0]   p_la;
  logic [WSEL_W-1:0] p_wsel;
  logic [WORD_W-1:0] p_wdata;
  logic [WB-1:0]     p_be;
  logic              p_wt, p_tr;

  // shared write port and merge path
  logic              in_wait;
  logic              wr_en, wr_tr, wr_dirty;
  logic [LA_W-1:0]   wr_la;
  logic [LINE_W-1:0] mg_base, mg_line, mg_mdata;
  logic [LINE_BYTES-1:0] mg_mbe;
  logic [WSEL_W-1:0] mg_wsel;
  logic [WORD_W-1:0] mg_wdata;
  logic [WB-1:0]     mg_be;

  // named events for the assertions
  logic wb_fire;
  logic noalloc_store_evt;
  logic page_nalloc_evt;

  function automatic logic [ADDR_W-1:0] line_addr(logic [LA_W-1:0] la);
    return {la, {OFF_W{1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(logic [LINE_W-1:0] ln, logic [WSEL_W-1:0] ws);
    return ln[int'(ws) * WORD_W +: WORD_W];
  endfunction

  // ---------------- lookup ----------------
  assign req_ready = (state_q == S_IDLE);
  assign acc       = req_valid & req_ready;
  assign req_la    = req_addr[ADDR_W-1:OFF_W];
  assign req_wsel  = req_addr[OFF_W-1:OFF_W-WSEL_W];
  assign req_tr    = pick_transient(cfg_transient_en, req_pg_tmark);

  assign sel_vld   = pv[req_tr];
  assign sel_dirty = pd[req_tr];
  assign sel_tag   = ptag[req_tr];
  assign sel_line  = pline[req_tr];
  assign hit       = req_cacheable & sel_vld & (sel_tag == req_la);

  dsa_policy u_policy (
    .is_store    (req_write),
    .cacheable   (req_cacheable),
    .hit         (hit),
    .g_noalloc   (cfg_store_noalloc),
    .page_ctl_en (cfg_page_alloc_en),
    .pg_nalloc   (req_pg_nalloc),
    .kind        (kind)
  );

  // ---------------- partitions ----------------
  for (genvar p = 0; p < NPART; p++) begin : g_part
    localparam int SETS_P = (p == 0) ? NORM_SETS : TRAN_SETS;
    localparam int IW     = $clog2(SETS_P);
    dsa_line_store #(
      .SETS   (SETS_P),
      .TAG_W  (LA_W),
      .LINE_W (LINE_W)
    ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (req_la[IW-1:0]),
      .rd_vld   (pv[p]),
      .rd_dirty (pd[p]),
      .rd_tag   (ptag[p]),
      .rd_line  (pline[p]),
      .wr_en    (wr_en && (wr_tr == (p != 0))),
      .wr_idx   (wr_la[IW-1:0]),
      .wr_tag   (wr_la),
      .wr_line  (mg_line),
      .wr_dirty (wr_dirty)
    );
  end

  // ---------------- merge / write port ----------------
  assign in_wait  = (state_q == S_WAIT);
  assign mg_base  = in_wait ? fill_data : sel_line;
  assign mg_wsel  = in_wait ? p_wsel    : req_wsel;
  assign mg_wdata = in_wait ? p_wdata   : req_wdata;
  assign mg_be    = in_wait ? p_be      : req_be;

  dsa_merge #(
    .WORD_W     (WORD_W),
    .LINE_BYTES (LINE_BYTES)
  ) u_merge (
    .base_line   (mg_base),
    .wsel        (mg_wsel),
    .wdata       (mg_wdata),
    .be          (mg_be),
    .merged_line (mg_line),
    .mem_data    (mg_mdata),
    .mem_be      (mg_mbe)
  );

  assign wr_en    = (acc && req_write && (kind == K_HIT)) || (in_wait && fill_valid);
  assign wr_tr    = in_wait ? p_tr : req_tr;
  assign wr_la    = in_wait ? p_la : req_la;
  assign wr_dirty = in_wait ? ~p_wt : (sel_dirty | ~req_wthru);

  assign noalloc_store_evt = acc && req_write && (kind == K_NOALLOC);
  assign page_nalloc_evt   = acc && req_write && req_cacheable && !hit
                             && cfg_page_alloc_en && req_pg_nalloc;

  // ---------------- sequencing ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= S_IDLE;
      rsp_valid      <= 1'b0;
      rsp_kind       <= K_HIT;
      rsp_hit        <= 1'b0;
      rsp_part       <= 1'b0;
      rsp_rdata      <= '0;
      fill_req_valid <= 1'b0;
      fill_req_addr  <= '0;
      mem_wr_valid   <= 1'b0;
      mem_wr_addr    <= '0;
      mem_wr_data    <= '0;
      mem_wr_be      <= '0;
      wb_fire        <= 1'b0;
      p_la           <= '0;
      p_wsel         <= '0;
      p_wdata        <= '0;
      p_be           <= '0;
      p_wt           <= 1'b0;
      p_tr           <= 1'b0;
    end else begin
      rsp_valid      <= 1'b0;
      fill_req_valid <= 1'b0;
      mem_wr_valid   <= 1'b0;
      wb_fire        <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (acc) begin
            p_la          <= req_la;
            p_wsel        <= req_wsel;
            p_wdata       <= req_wdata;
            p_be          <= req_be;
            p_wt          <= req_wthru;
            p_tr          <= req_tr;
            fill_req_addr <= line_addr(req_la);
            if (kind == K_ALLOC) begin
              if (sel_vld && sel_dirty) begin
                mem_wr_valid <= 1'b1;
                mem_wr_addr  <= line_addr(sel_tag);
                mem_wr_data  <= sel_line;
                mem_wr_be    <= '1;
                wb_fire      <= 1'b1;
                state_q      <= S_WB;
              end else begin
                fill_req_valid <= 1'b1;
                state_q        <= S_WAIT;
              end
            end else begin
              rsp_valid <= 1'b1;
              rsp_kind  <= kind;
              rsp_hit   <= hit;
              rsp_part  <= req_tr;
              rsp_rdata <= (hit && !req_write) ? pick_word(sel_line, req_wsel) : '0;
              if (req_write && (kind != K_HIT || req_wthru)) begin
                mem_wr_valid <= 1'b1;
                mem_wr_addr  <= line_addr(req_la);
                mem_wr_data  <= mg_mdata;
                mem_wr_be    <= mg_mbe;
              end
            end
          end
        end
        S_WB: begin
          fill_req_valid <= 1'b1;
          state_q        <= S_WAIT;
        end
        S_WAIT: begin
          if (fill_valid) begin
            rsp_valid <= 1'b1;
            rsp_kind  <= K_ALLOC;
            rsp_hit   <= 1'b0;
            rsp_part  <= p_tr;
            rsp_rdata <= '0;
            if (p_wt) begin
              mem_wr_valid <= 1'b1;
              mem_wr_addr  <= line_addr(p_la);
              mem_wr_data  <= mg_mdata;
              mem_wr_be    <= mg_mbe;
            end
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  // R10: a fill request is only seen while the request port is closed
  p_fill_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> !req_ready)
    else $error("fill request while ready");

  // R9: a write-back is followed by the fill request in the next cycle
  p_wb_precedes_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> fill_req_valid)
    else $error("write-back not followed by fill");

  // R9: write-back covers the whole line
  p_wb_full_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> (mem_wr_valid && (mem_wr_be == '1)))
    else $error("write-back not full line");

  // R5: non-allocating store goes to memory without a fill
  p_noalloc_no_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    noalloc_store_evt |=> (mem_wr_valid && !fill_req_valid && rsp_valid))
    else $error("non-allocating store misbehaved");

  // R2: page no-allocate wins when page control is enabled
  p_page_overrides_r2: assert property (@(posedge clk) disable iff (!rst_n)
    page_nalloc_evt |=> (rsp_valid && rsp_kind == K_NOALLOC))
    else $error("page attribute ignored");

  // R6: without the transient enable every access is normal
  p_normal_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cfg_transient_en) |=> !rsp_part)
    else $error("transient partition used while disabled");

endmodule

// File: tb/dc_store_alloc_tb.sv
module dc_store_alloc_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n;
  logic         req_valid, req_ready, req_write;
  logic [31:0]  req_addr, req_wdata;
  logic [3:0]   req_be;
  logic         req_cacheable, req_wthru, req_pg_tmark, req_pg_nalloc;
  logic         cfg_store_noalloc, cfg_page_alloc_en, cfg_transient_en;
  logic         rsp_valid, rsp_hit, rsp_part;
  logic [1:0]   rsp_kind;
  logic [31:0]  rsp_rdata;
  logic         fill_req_valid, fill_valid;
  logic [31:0]  fill_req_addr;
  logic [127:0] fill_data;
  logic         mem_wr_valid;
  logic [31:0]  mem_wr_addr;
  logic [127:0] mem_wr_data;
  logic [15:0]  mem_wr_be;

  dc_store_alloc u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_cacheable(req_cacheable), .req_wthru(req_wthru),
    .req_pg_tmark(req_pg_tmark), .req_pg_nalloc(req_pg_nalloc),
    .cfg_store_noalloc(cfg_store_noalloc), .cfg_page_alloc_en(cfg_page_alloc_en),
    .cfg_transient_en(cfg_transient_en),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_hit(rsp_hit),
    .rsp_part(rsp_part), .rsp_rdata(rsp_rdata),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
  );

  int n_chk = 0;
  int n_err = 0;

  // reference model: [partition][set]
  logic         mv [2][8];
  logic         md [2][8];
  logic [27:0]  mt [2][8];
  logic [127:0] ml [2][8];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] fill_pat(logic [27:0] la);
    return {32'(la) ^ 32'hA5A5_0000, 32'(la) + 32'd1, ~{4'h0, la}, {la, 4'h7}};
  endfunction

  function automatic logic [127:0] put_word(logic [127:0] ln, int ws, logic [31:0] wd, logic [3:0] be);
    for (int b = 0; b < 4; b++)
      if (be[b]) ln[ws*32 + b*8 +: 8] = wd[b*8 +: 8];
    return ln;
  endfunction

  task automatic quiet(input string tag);
    chk(!rsp_valid && !mem_wr_valid && !fill_req_valid, tag, {rsp_valid, mem_wr_valid, fill_req_valid}, 0);
    chk(req_ready, tag, req_ready, 1);
  endtask

  // one request, checked every cycle until it is complete
  task automatic op(input bit wr, input logic [31:0] a, input logic [31:0] wd, input logic [3:0] be,
                    input bit c, input bit wt, input bit tm, input bit na, input int fdly);
    logic [27:0]  la;
    int           ws, idx;
    bit           tr, hit, alloc, memw;
    logic [15:0]  sbe;
    logic [127:0] sdat, nline;
    logic [1:0]   ekind;
    la    = a[31:4];
    ws    = int'(a[3:2]);
    tr    = cfg_transient_en && tm;
    idx   = tr ? int'(la % 2) : int'(la % 8);
    hit   = c && mv[tr][idx] && (mt[tr][idx] == la);
    alloc = cfg_page_alloc_en ? !na : !cfg_store_noalloc;
    sbe   = 16'(be) << (ws * 4);
    sdat  = {4{wd}};

    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    req_cacheable = c; req_wthru = wt; req_pg_tmark = tm; req_pg_nalloc = na;
    chk(req_ready, "R10 ready before request", req_ready, 1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;

    if (wr && c && !hit && alloc) begin
      if (mv[tr][idx] && md[tr][idx]) begin
        chk(mem_wr_valid && !fill_req_valid, "R9 write-back pulse", {mem_wr_valid, fill_req_valid}, 2'b10);
        chk(mem_wr_addr == {mt[tr][idx], 4'h0}, "R9 write-back addr", mem_wr_addr, {mt[tr][idx], 4'h0});
        chk(mem_wr_data == ml[tr][idx], "R9 write-back data", mem_wr_data, ml[tr][idx]);
        chk(mem_wr_be == 16'hFFFF, "R9 write-back be", mem_wr_be, 16'hFFFF);
        @(negedge clk);
      end
      chk(fill_req_valid && !mem_wr_valid && !rsp_valid, "R3 fill request", {fill_req_valid, mem_wr_valid, rsp_valid}, 3'b100);
      chk(fill_req_addr == {la, 4'h0}, "R3 fill address", fill_req_addr, {la, 4'h0});
      chk(!req_ready, "R10 busy during fill", req_ready, 0);
      for (int d = 0; d < fdly; d++) begin
        if (d == 0) begin
          // stray non-cacheable store held while busy
          req_valid = 1'b1; req_write = 1'b1; req_cacheable = 1'b0; req_addr = 32'h0000_0F00;
        end
        @(negedge clk);
        chk(!fill_req_valid && !mem_wr_valid && !rsp_valid, "R10 idle while waiting", {fill_req_valid, mem_wr_valid, rsp_valid}, 0);
        chk(!req_ready, "R10 ready low while waiting", req_ready, 0);
      end
      req_valid = 1'b0;
      fill_valid = 1'b1; fill_data = fill_pat(la);
      @(posedge clk); @(negedge clk);
      fill_valid = 1'b0; fill_data = '0;
      nline = put_word(fill_pat(la), ws, wd, be);
      mv[tr][idx] = 1'b1; mt[tr][idx] = la; ml[tr][idx] = nline; md[tr][idx] = !wt;
      chk(rsp_valid && rsp_kind == 2'd1, "R3 alloc response", {rsp_valid, rsp_kind}, 3'b101);
      chk(rsp_part == tr, "R6 partition alloc", rsp_part, tr);
      chk(mem_wr_valid == wt, "R4 write-through on alloc", mem_wr_valid, wt);
      if (wt) begin
        chk(mem_wr_addr == {la, 4'h0} && mem_wr_be == sbe, "R4 alloc write addr/be", {mem_wr_addr, mem_wr_be}, {la, 4'h0, sbe});
        chk(mem_wr_data == sdat, "R4 alloc write data", mem_wr_data, sdat);
      end
      chk(req_ready, "R10 ready after fill", req_ready, 1);
    end else begin
      ekind = !c ? 2'd3 : hit ? 2'd0 : 2'd2;
      memw  = wr && (!c || !hit || wt);
      chk(rsp_valid && rsp_kind == ekind, wr ? "R1 R2 R7 R8 store kind" : "R11 load kind", {rsp_valid, rsp_kind}, {1'b1, ekind});
      chk(rsp_hit == hit, "R11 hit flag", rsp_hit, hit);
      chk(rsp_part == tr, "R6 partition", rsp_part, tr);
      chk(!fill_req_valid, "R5 no fill", fill_req_valid, 0);
      chk(mem_wr_valid == memw, "R5 R7 R8 memory write", mem_wr_valid, memw);
      if (memw) begin
        chk(mem_wr_addr == {la, 4'h0}, "R5 write addr", mem_wr_addr, {la, 4'h0});
        chk(mem_wr_be == sbe, "R5 write be", mem_wr_be, sbe);
        chk(mem_wr_data == sdat, "R5 write data", mem_wr_data, sdat);
      end
      if (!wr) chk(rsp_rdata == (hit ? ml[tr][idx][ws*32 +: 32] : 32'h0), "R11 load data",
                   rsp_rdata, hit ? ml[tr][idx][ws*32 +: 32] : 32'h0);
      if (wr && hit) begin
        ml[tr][idx] = put_word(ml[tr][idx], ws, wd, be);
        md[tr][idx] = md[tr][idx] | !wt;
      end
    end
    @(negedge clk);
    quiet("R10 quiet after request");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog expired act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 8; s++) begin
        mv[p][s] = 0; md[p][s] = 0; mt[p][s] = '0; ml[p][s] = '0;
      end
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; req_be = 0;
    req_cacheable = 0; req_wthru = 0; req_pg_tmark = 0; req_pg_nalloc = 0;
    cfg_store_noalloc = 0; cfg_page_alloc_en = 0; cfg_transient_en = 0;
    fill_valid = 0; fill_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    quiet("R12 reset outputs");
    op(0, 32'h100, 0, 0, 1, 0, 0, 0, 0);                      // R12 lines invalid, R11 miss

    // R1 global control
    op(1, 32'h104, 32'h1122_3344, 4'hF, 1, 0, 0, 0, 3);       // R1 allocate, R4 dirty
    op(0, 32'h104, 0, 0, 1, 0, 0, 0, 0);                      // R3 merged data
    op(0, 32'h100, 0, 0, 1, 0, 0, 0, 0);                      // R3 fill data kept
    cfg_store_noalloc = 1;
    op(1, 32'h208, 32'hDEAD_BEEF, 4'b0110, 1, 0, 0, 0, 0);    // R1 R5 no allocate
    op(0, 32'h208, 0, 0, 1, 0, 0, 0, 0);                      // R5 cache unchanged

    // R2 page control
    cfg_page_alloc_en = 1;
    op(1, 32'h314, 32'hCAFE_0001, 4'b0011, 1, 1, 0, 0, 0);    // R2 allocate despite global, R4 write-through
    cfg_store_noalloc = 0;
    op(1, 32'h48C, 32'h7700_0000, 4'b1000, 1, 0, 0, 1, 0);    // R2 no allocate despite global
    op(0, 32'h48C, 0, 0, 1, 0, 0, 0, 0);

    // R8 store hits
    cfg_page_alloc_en = 0;
    op(1, 32'h108, 32'h0BAD_F00D, 4'b1101, 1, 0, 0, 0, 0);    // R8 hit, dirty
    op(1, 32'h31C, 32'h1234_5678, 4'hF, 1, 1, 0, 0, 0);       // R8 hit, write-through
    op(0, 32'h108, 0, 0, 1, 0, 0, 0, 0);
    op(0, 32'h31C, 0, 0, 1, 0, 0, 0, 0);

    // R9 dirty eviction in the normal partition
    op(1, 32'h18C, 32'hAAAA_5555, 4'b0101, 1, 0, 0, 0, 2);
    op(0, 32'h18C, 0, 0, 1, 0, 0, 0, 0);
    op(0, 32'h104, 0, 0, 1, 0, 0, 0, 0);

    // R6 transient partition
    cfg_transient_en = 1;
    op(1, 32'h520, 32'h0F0F_0F0F, 4'hF, 1, 0, 1, 0, 1);
    op(0, 32'h520, 0, 0, 1, 0, 0, 0, 0);                      // normal side misses
    op(0, 32'h520, 0, 0, 1, 0, 1, 0, 0);                      // transient side hits
    cfg_transient_en = 0;
    op(0, 32'h520, 0, 0, 1, 0, 1, 0, 0);                      // R6 mark ignored when disabled
    cfg_transient_en = 1;
    op(1, 32'h544, 32'h9999_8888, 4'b1100, 1, 0, 1, 0, 1);    // R9 transient eviction
    op(0, 32'h520, 0, 0, 1, 0, 1, 0, 0);
    op(0, 32'h544, 0, 0, 1, 0, 1, 0, 0);
    cfg_transient_en = 0;

    // R7 non-cacheable store leaves cached copy alone
    op(1, 32'h184, 32'h5151_5151, 4'hF, 0, 0, 0, 0, 0);
    op(0, 32'h184, 0, 0, 1, 0, 0, 0, 0);
    op(0, 32'h184, 0, 0, 0, 0, 0, 0, 0);                      // R11 non-cacheable load

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule